// File: doc/BRIEF.md
# Universal Bidirectional Bus Register Transceiver

This block moves an 18-bit word in two directions between an A side and a B side. Each direction has its own 18-bit storage element. The latch enable for that direction chooses how the element behaves:

- With the latch enable high, the element is a transparent latch.
- With the latch enable low and its bus clock steady, it holds its value.
- With the latch enable low, a falling edge of its bus clock captures the input, so it acts as a falling-edge register.

Each direction also has an output enable. The A-to-B enable is active-high and the B-to-A enable is active-low.

The design is synchronous to one system clock `clk`. The two bus clocks are treated as data inputs and are sampled on each rising edge of `clk`. A falling edge of a bus clock counts when it was high at one `clk` edge and low at the next. Each tri-state bus output is modelled as a data word plus a drive flag. The data word always shows the value the direction would present, and the drive flag is the enable.

A synchronous active-high reset clears both storage elements and both bus clock histories.

Top module: `ubt_transceiver`

## Requirements
- R1: Each direction has its own 18-bit storage element. Activity on the B-to-A inputs and controls never changes `b_out`, and activity on the A-to-B inputs and controls never changes `a_out`.
- R2: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle (combinational pass-through). The storage element also loads `a_in` on every `clk` edge.
- R3: While `ab_le` is 0 and no falling edge of `ab_clk` is sampled, `b_out` keeps the stored value, whatever `a_in` does. A rising edge of `ab_clk` does not load.
- R4: While `ab_le` is 0, a falling edge of `ab_clk` loads `a_in` at the `clk` edge where the fall is seen. A fall is seen when `ab_clk` was sampled 1 at the previous `clk` edge and 0 at this one. `b_out` shows the loaded value right after that edge.
- R5: `b_drive` is 1 exactly when `ab_oe` is 1 (active-high). When `b_drive` is 0 the B bus is high-impedance, but `b_out` still carries the word that would be driven.
- R6: The B-to-A path behaves the same way, using `ba_le`, `ba_clk`, `b_in` and `a_out`. `a_drive` is 1 exactly when `ba_oe_n` is 0 (active-low).
- R7: If the latch enable falls while the bus clock is high, the output holds the value loaded at the last `clk` edge with the latch enable high. The next falling edge of the bus clock loads new data.
- R8: Storage loads while the direction's drive flag is 0. Re-enabling the output shows the newly loaded word.
- R9: When `rst` is 1 at a `clk` edge, both storage elements and both bus clock histories become 0. With the latch enables low, both outputs then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Word arriving on the A side |
| b_in | input | 18 | Word arriving on the B side |
| ab_le | input | 1 | A-to-B latch enable |
| ab_clk | input | 1 | A-to-B bus clock, loads on falling edge |
| ab_oe | input | 1 | A-to-B output enable, active-high |
| ba_le | input | 1 | B-to-A latch enable |
| ba_clk | input | 1 | B-to-A bus clock, loads on falling edge |
| ba_oe_n | input | 1 | B-to-A output enable, active-low |
| b_out | output | 18 | Word presented on the B side |
| b_drive | output | 1 | B side drive flag (0 = high-impedance) |
| a_out | output | 18 | Word presented on the A side |
| a_drive | output | 1 | A side drive flag (0 = high-impedance) |

## Verification
The assertions check the following on every cycle, in both directions:
- transparent pass-through;
- holding while no falling edge is seen;
- loading on a sampled fall;
- the polarity of each drive flag;
- the cleared state after reset.

Some behaviour shows only across a sequence of cycles, so only the bench scenarios can demonstrate it:
- a word survives a disable/enable cycle;
- a load happens while the output is disabled;
- the latch enable falls while the bus clock is high, and the value is held until a later fall;
- the two directions are independent.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int BUS_W = 18;

    typedef enum logic [1:0] {
        STORE_HOLD    = 2'd0,
        STORE_PASS    = 2'd1,
        STORE_CAPTURE = 2'd2
    } store_mode_e;

    typedef struct packed {
        logic le;
        logic bclk;
        logic oe;
    } lane_ctl_t;

    function automatic store_mode_e pick_mode(input logic le, input logic fall);
        if (le)
            return STORE_PASS;
        else if (fall)
            return STORE_CAPTURE;
        else
            return STORE_HOLD;
    endfunction

endpackage

// File: rtl/ubt_fall_detect.sv
module ubt_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= sig;
    end

    assign fall = prev_q & ~sig;
endmodule

// File: rtl/ubt_store_cell.sv
module ubt_store_cell
    import ubt_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  store_mode_e  mode,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (mode != STORE_HOLD)
            q <= din;
    end
endmodule

// File: rtl/ubt_out_gate.sv
module ubt_out_gate #(
    parameter int W       = 18,
    parameter bit ACT_LOW = 1'b0
) (
    input  logic         le,
    input  logic [W-1:0] din,
    input  logic [W-1:0] stored,
    input  logic         oe_raw,
    output logic [W-1:0] dout,
    output logic         drive
);
    assign dout = le ? din : stored;

    generate
        if (ACT_LOW) begin : g_low
            assign drive = ~oe_raw;
        end else begin : g_high
            assign drive = oe_raw;
        end
    endgenerate
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
    import ubt_pkg::*;
#(
    parameter int W       = BUS_W,
    parameter bit ACT_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctl_t    ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive
);
    logic         fall;
    store_mode_e  mode;
    logic [W-1:0] stored;

    ubt_fall_detect u_fall (
        .clk  (clk),
        .rst  (rst),
        .sig  (ctl.bclk),
        .fall (fall)
    );

    assign mode = pick_mode(ctl.le, fall);

    ubt_store_cell #(.W(W)) u_cell (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .din  (din),
        .q    (stored)
    );

    ubt_out_gate #(.W(W), .ACT_LOW(ACT_LOW)) u_gate (
        .le     (ctl.le),
        .din    (din),
        .stored (stored),
        .oe_raw (ctl.oe),
        .dout   (dout),
        .drive  (drive)
    );
endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver
    import ubt_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_le,
    input  logic         ab_clk,
    input  logic         ab_oe,
    input  logic         ba_le,
    input  logic         ba_clk,
    input  logic         ba_oe_n,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    output logic [W-1:0] a_out,
    output logic         a_drive
);
    lane_ctl_t ab_ctl;
    lane_ctl_t ba_ctl;

    assign ab_ctl = '{le: ab_le, bclk: ab_clk, oe: ab_oe};
    assign ba_ctl = '{le: ba_le, bclk: ba_clk, oe: ba_oe_n};

    ubt_lane #(.W(W), .ACT_LOW(1'b0)) u_ab (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ab_ctl),
        .din   (a_in),
        .dout  (b_out),
        .drive (b_drive)
    );

    ubt_lane #(.W(W), .ACT_LOW(1'b1)) u_ba (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ba_ctl),
        .din   (b_in),
        .dout  (a_out),
        .drive (a_drive)
    );
endmodule

// File: rtl/ubt_transceiver_chk.sv
module ubt_transceiver_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_le,
    input logic         ab_clk,
    input logic         ab_oe,
    input logic         ba_le,
    input logic         ba_clk,
    input logic         ba_oe_n,
    input logic [W-1:0] b_out,
    input logic         b_drive,
    input logic [W-1:0] a_out,
    input logic         a_drive
);
    // R2 / R6: transparent pass-through in each direction
    p_pass_ab_r2: assert property (@(posedge clk) disable iff (rst)
        ab_le |-> b_out == a_in);
    p_pass_ba_r6: assert property (@(posedge clk) disable iff (rst)
        ba_le |-> a_out == b_in);

    // R3: with no sampled fall, the held word stays put while the enable stays low
    p_hold_ab_r3: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && !($past(ab_clk) && !ab_clk)) |=> (ab_le || $stable(b_out)));
    p_hold_ba_r6: assert property (@(posedge clk) disable iff (rst)
        (!ba_le && !($past(ba_clk) && !ba_clk)) |=> (ba_le || $stable(a_out)));

    // R4: a sampled fall loads the input present at that edge
    p_capture_ab_r4: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && !$past(rst) && $past(ab_clk) && !ab_clk)
        |=> (ab_le || b_out == $past(a_in)));
    p_capture_ba_r6: assert property (@(posedge clk) disable iff (rst)
        (!ba_le && !$past(rst) && $past(ba_clk) && !ba_clk)
        |=> (ba_le || a_out == $past(b_in)));

    // R5 / R6: drive flag polarity
    p_drive_ab_r5: assert property (@(posedge clk) disable iff (rst)
        b_drive == ab_oe);
    p_drive_ba_r6: assert property (@(posedge clk) disable iff (rst)
        a_drive == !ba_oe_n);

    // R9: cleared storage right after reset
    p_reset_ab_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !ab_le) |-> b_out == '0);
    p_reset_ba_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !ba_le) |-> a_out == '0);
endmodule

bind ubt_transceiver ubt_transceiver_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a_in    (a_in),
    .b_in    (b_in),
    .ab_le   (ab_le),
    .ab_clk  (ab_clk),
    .ab_oe   (ab_oe),
    .ba_le   (ba_le),
    .ba_clk  (ba_clk),
    .ba_oe_n (ba_oe_n),
    .b_out   (b_out),
    .b_drive (b_drive),
    .a_out   (a_out),
    .a_drive (a_drive)
);

// File: tb/ubt_transceiver_tb.sv
module ubt_transceiver_tb;
    localparam int W = 18;
    localparam logic [W-1:0] MASK = 18'h2D2D2;
    localparam int NV = 12;

    // each row: le, bus clk, enable (logical), input word, expected word
    typedef struct packed {
        logic         le;
        logic         bclk;
        logic         en;
        logic [W-1:0] din;
        logic [W-1:0] exp;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 18'h12345, 18'h12345},  // R2 pass
        '{1'b1, 1'b0, 1'b1, 18'h2AAAA, 18'h2AAAA},  // R2 pass
        '{1'b0, 1'b0, 1'b1, 18'h15555, 18'h2AAAA},  // R3 hold
        '{1'b0, 1'b1, 1'b1, 18'h0F0F0, 18'h2AAAA},  // R3 rise no load
        '{1'b0, 1'b0, 1'b1, 18'h3C3C3, 18'h3C3C3},  // R4 fall loads
        '{1'b0, 1'b0, 1'b0, 18'h00FFF, 18'h3C3C3},  // R5 disabled
        '{1'b0, 1'b1, 1'b0, 18'h11111, 18'h3C3C3},  // R5 disabled hold
        '{1'b0, 1'b0, 1'b0, 18'h22222, 18'h22222},  // R8 load while off
        '{1'b0, 1'b0, 1'b1, 18'h33333, 18'h22222},  // R8 survives
        '{1'b1, 1'b1, 1'b1, 18'h04040, 18'h04040},  // R2 pass, clk high
        '{1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h04040},  // R7 le falls, clk high
        '{1'b0, 1'b0, 1'b1, 18'h01234, 18'h01234}   // R7 later fall loads
    };

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         ab_le, ab_clk, ab_oe, ba_le, ba_clk, ba_oe_n;
    logic [W-1:0] b_out, a_out;
    logic         b_drive, a_drive;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    ubt_transceiver #(.W(W)) u_dut (
        .clk (clk), .rst (rst),
        .a_in (a_in), .b_in (b_in),
        .ab_le (ab_le), .ab_clk (ab_clk), .ab_oe (ab_oe),
        .ba_le (ba_le), .ba_clk (ba_clk), .ba_oe_n (ba_oe_n),
        .b_out (b_out), .b_drive (b_drive),
        .a_out (a_out), .a_drive (a_drive)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // drive after falling edge, sample 2 ns after the next rising edge
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        rst = 1'b1; a_in = '0; b_in = '0;
        ab_le = 1'b0; ab_clk = 1'b0; ab_oe = 1'b0;
        ba_le = 1'b0; ba_clk = 1'b0; ba_oe_n = 1'b1;
        step(); step();
        @(negedge clk); rst = 1'b0;
        a_in = 18'h3FFFF; b_in = 18'h3FFFF;
        step();
        // R9 reset state
        chk("R9 b_out after reset", b_out, '0);
        chk("R9 a_out after reset", a_out, '0);
        chk("R5 b_drive off", {17'd0, b_drive}, 18'd0);
        chk("R6 a_drive off (oe_n=1)", {17'd0, a_drive}, 18'd0);

        // Table walk: both directions at once, B side uses masked data
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ab_le = VECS[i].le; ab_clk = VECS[i].bclk; ab_oe = VECS[i].en;
            a_in  = VECS[i].din;
            ba_le = VECS[i].le; ba_clk = VECS[i].bclk; ba_oe_n = ~VECS[i].en;
            b_in  = VECS[i].din ^ MASK;
            step();
            chk("R2/R3/R4/R7/R8 b_out", b_out, VECS[i].exp);
            chk("R6 a_out", a_out, VECS[i].exp ^ MASK);
            chk("R5 b_drive", {17'd0, b_drive}, {17'd0, VECS[i].en});
            chk("R6 a_drive", {17'd0, a_drive}, {17'd0, VECS[i].en});
        end

        // R1 independence: B-to-A path loads while A-to-B holds
        held = b_out;
        @(negedge clk); ba_le = 1'b1; b_in = 18'h1ABCD; a_in = 18'h2FEDC; ab_le = 1'b0; ab_clk = 1'b0;
        step();
        chk("R1 a_out pass", a_out, 18'h1ABCD);
        chk("R1 b_out untouched", b_out, held);
        @(negedge clk); ba_clk = 1'b1; ba_le = 1'b0; b_in = 18'h00001;
        step();
        @(negedge clk); ba_clk = 1'b0; b_in = 18'h00002;
        step();
        chk("R6 B-to-A fall loads", a_out, 18'h00002);
        chk("R1 b_out still untouched", b_out, held);

        // R9 mid-run reset
        @(negedge clk); rst = 1'b1;
        step();
        @(negedge clk); rst = 1'b0;
        step();
        chk("R9 b_out mid-run reset", b_out, '0);
        chk("R9 a_out mid-run reset", a_out, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule